// File: doc/BRIEF.md
# Program Sequencer with Circular Return Stack

This block sequences instruction addresses for a small 8-bit controller. It holds a 13-bit program counter and picks its next value each clock from one of several sources: step to the next word, a direct write of the low byte from the data bus, a jump or call target taken from an 11-bit instruction field, a return address taken from an internal stack, or the fixed interrupt entry address. The upper counter bits for byte writes and jumps come from a separate 5-bit high-address latch. Software fills this latch through its own strobe. A byte write uses all five latch bits, while a jump or call uses only the top two.

Calls and interrupt entries push a return address onto an eight-entry, 13-bit stack. Returns pop it. The stack pointer cannot be seen from outside. The stack wraps silently, so the ninth push overwrites the oldest entry. Popping more entries than were pushed returns whatever slot the wrapped pointer selects. Program memory holds 2k words, so the fetch address is the low 11 bits of the counter and every higher address wraps into that range.

Top module: `prog_seq`

## Requirements
- R1: While rst_n is low, pc_o is 0000h, the high-address latch is 0 and every stack entry is 0. A return issued straight after reset therefore yields pc_o = 0000h.
- R2: When step_i is the only active strobe, pc_o advances by one in the next cycle. It wraps from 1FFFh to 0000h.
- R3: A low-byte write (pcl_wr_i) loads pc_o with {latch[4:0], data_i[7:0]}.
- R4: A jump (goto_i) loads pc_o with {latch[4:3], target_i[10:0]} and leaves the stack untouched.
- R5: A call (call_i) loads pc_o the same way as a jump and pushes pc_o+1.
- R6: A return (ret_i) loads pc_o with the most recently pushed value that has not yet been popped, and moves the stack pointer back by one.
- R7: An interrupt (irq_i) loads pc_o with 0004h and pushes the current pc_o, which is the word that was about to execute.
- R8: When several strobes are active together, the order is irq_i, then call_i, then goto_i, then ret_i, then pcl_wr_i, then step_i. Only the winner acts, and the losers have no effect on pc_o or the stack. With no strobe active, pc_o holds.
- R9: The stack is circular with eight entries. The ninth push replaces the first pushed value. After nine pushes, nine pops return the 9th, 8th, ..., 2nd values and then the 9th again. There is no error indication.
- R10: Only hi_wr_i changes the latch, loading data_i[4:0]. Pushes and pops do not touch it. A load that uses the latch in the same cycle as a latch write sees the previous latch value.
- R11: fetch_addr_o always equals pc_o[10:0].
- R12: pcl_o always equals pc_o[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Advance to next word |
| pcl_wr_i | input | 1 | Load counter low byte from data_i |
| goto_i | input | 1 | Jump to target_i |
| call_i | input | 1 | Call target_i, push return address |
| ret_i | input | 1 | Return (pop) |
| irq_i | input | 1 | Interrupt entry |
| hi_wr_i | input | 1 | Write high-address latch from data_i[4:0] |
| target_i | input | 11 | Jump/call target field |
| data_i | input | 8 | Data bus |
| pc_o | output | 13 | Program counter |
| pcl_o | output | 8 | Readable low byte of the counter |
| fetch_addr_o | output | 11 | Program memory word address |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a latch write together with a counter load that reads the latch, either a low-byte write or a jump. The bench provokes this with directed cycles and judges it by whether the new counter carries the old latch bits. The second pair is an interrupt together with a return, which checks that the pop is discarded and that the interrupt push lands on the live top of the stack. Random cycles also raise many strobes at once and compare every result against a priority model kept in the bench.

// File: rtl/prog_seq_pkg.sv
`timescale 1ns/1ps
package prog_seq_pkg;
   typedef enum logic [2:0] {
      SRC_HOLD = 3'd0,
      SRC_STEP = 3'd1,
      SRC_BYTE = 3'd2,
      SRC_JUMP = 3'd3,
      SRC_POP  = 3'd4,
      SRC_VEC  = 3'd5
   } pc_src_e;
endpackage

// File: rtl/prog_seq_arb.sv
`timescale 1ns/1ps
module prog_seq_arb
   import prog_seq_pkg::*;
(
   input  logic    step_i,
   input  logic    pcl_wr_i,
   input  logic    goto_i,
   input  logic    call_i,
   input  logic    ret_i,
   input  logic    irq_i,
   output pc_src_e src_o,
   output logic    push_o,
   output logic    push_cur_o,
   output logic    pop_o
);
   always_comb begin
      src_o      = SRC_HOLD;
      push_o     = 1'b0;
      push_cur_o = 1'b0;
      pop_o      = 1'b0;
      if (irq_i) begin
         src_o      = SRC_VEC;
         push_o     = 1'b1;
         push_cur_o = 1'b1;
      end else if (call_i) begin
         src_o  = SRC_JUMP;
         push_o = 1'b1;
      end else if (goto_i) begin
         src_o = SRC_JUMP;
      end else if (ret_i) begin
         src_o = SRC_POP;
         pop_o = 1'b1;
      end else if (pcl_wr_i) begin
         src_o = SRC_BYTE;
      end else if (step_i) begin
         src_o = SRC_STEP;
      end
   end
endmodule

// File: rtl/prog_seq_next.sv
`timescale 1ns/1ps
module prog_seq_next
   import prog_seq_pkg::*;
#(
   parameter int PC_W    = 13,
   parameter int TGT_W   = 11,
   parameter int DATA_W  = 8,
   parameter int LATCH_W = 5,
   parameter int VECTOR  = 4
) (
   input  pc_src_e            src_i,
   input  logic [PC_W-1:0]    pc_i,
   input  logic [LATCH_W-1:0] latch_i,
   input  logic [DATA_W-1:0]  data_i,
   input  logic [TGT_W-1:0]   target_i,
   input  logic [PC_W-1:0]    stack_top_i,
   output logic [PC_W-1:0]    next_o
);
   localparam int JHI_W = PC_W - TGT_W;

   logic [PC_W-1:0] jump_addr;
   logic [PC_W-1:0] byte_addr;

   assign jump_addr = {latch_i[LATCH_W-1 -: JHI_W], target_i};
   assign byte_addr = {latch_i, data_i};

   always_comb begin
      unique case (src_i)
         SRC_STEP: next_o = pc_i + 1'b1;
         SRC_BYTE: next_o = byte_addr;
         SRC_JUMP: next_o = jump_addr;
         SRC_POP:  next_o = stack_top_i;
         SRC_VEC:  next_o = PC_W'(VECTOR);
         default:  next_o = pc_i;
      endcase
   end
endmodule

// File: rtl/prog_seq_stack.sv
`timescale 1ns/1ps
module prog_seq_stack #(
   parameter int W            = 13,
   parameter int DEPTH        = 8,
   parameter bit CLR_ON_RESET = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic         pop_i,
   input  logic [W-1:0] push_val_i,
   output logic [W-1:0] top_o
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] ptr_q;
   logic [PTR_W-1:0] top_idx;

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_depth_bad
      $error("stack depth must be a power of two of at least 2");
   end

   assign top_idx = ptr_q - 1'b1;
   assign top_o   = mem[top_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr_q <= '0;
      else if (push_i) ptr_q <= ptr_q + 1'b1;
      else if (pop_i)  ptr_q <= ptr_q - 1'b1;
   end

   if (CLR_ON_RESET) begin : g_clr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (push_i) begin
            mem[ptr_q] <= push_val_i;
         end
      end
   end else begin : g_keep
      always_ff @(posedge clk) begin
         if (push_i) mem[ptr_q] <= push_val_i;
      end
   end

   // R8
   push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(push_i && pop_i));
   // R9
   push_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |=> ptr_q == PTR_W'($past(ptr_q) + 1'b1));
   // R5
   push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |=> top_o == $past(push_val_i));
   // R6
   pop_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |=> ptr_q == PTR_W'($past(ptr_q) - 1'b1));
endmodule

// File: rtl/prog_seq.sv
`timescale 1ns/1ps
module prog_seq
   import prog_seq_pkg::*;
#(
   parameter int PC_W        = 13,
   parameter int TGT_W       = 11,
   parameter int IMPL_W      = 11,
   parameter int DATA_W      = 8,
   parameter int LATCH_W     = 5,
   parameter int STACK_DEPTH = 8,
   parameter int VECTOR      = 4,
   parameter bit STACK_CLR   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   input  logic              pcl_wr_i,
   input  logic              goto_i,
   input  logic              call_i,
   input  logic              ret_i,
   input  logic              irq_i,
   input  logic              hi_wr_i,
   input  logic [TGT_W-1:0]  target_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [PC_W-1:0]   pc_o,
   output logic [DATA_W-1:0] pcl_o,
   output logic [IMPL_W-1:0] fetch_addr_o
);
   if (LATCH_W + DATA_W != PC_W) begin : g_byte_bad
      $error("latch plus data width must equal counter width");
   end
   if (TGT_W >= PC_W || PC_W - TGT_W > LATCH_W) begin : g_tgt_bad
      $error("target field does not fit the counter and latch");
   end
   if (IMPL_W > PC_W || LATCH_W > DATA_W) begin : g_impl_bad
      $error("implemented space or latch width out of range");
   end

   pc_src_e            src;
   logic               push, push_cur, pop;
   logic [PC_W-1:0]    pc_q, pc_next, stack_top, push_val;
   logic [LATCH_W-1:0] latch_q;

   prog_seq_arb u_arb (
      .step_i     (step_i),
      .pcl_wr_i   (pcl_wr_i),
      .goto_i     (goto_i),
      .call_i     (call_i),
      .ret_i      (ret_i),
      .irq_i      (irq_i),
      .src_o      (src),
      .push_o     (push),
      .push_cur_o (push_cur),
      .pop_o      (pop)
   );

   prog_seq_next #(
      .PC_W (PC_W), .TGT_W (TGT_W), .DATA_W (DATA_W),
      .LATCH_W (LATCH_W), .VECTOR (VECTOR)
   ) u_next (
      .src_i       (src),
      .pc_i        (pc_q),
      .latch_i     (latch_q),
      .data_i      (data_i),
      .target_i    (target_i),
      .stack_top_i (stack_top),
      .next_o      (pc_next)
   );

   assign push_val = push_cur ? pc_q : pc_q + 1'b1;

   prog_seq_stack #(
      .W (PC_W), .DEPTH (STACK_DEPTH), .CLR_ON_RESET (STACK_CLR)
   ) u_stack (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_i     (push),
      .pop_i      (pop),
      .push_val_i (push_val),
      .top_o      (stack_top)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       latch_q <= '0;
      else if (hi_wr_i) latch_q <= data_i[LATCH_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= '0;
      else        pc_q <= pc_next;
   end

   assign pc_o         = pc_q;
   assign pcl_o        = pc_q[DATA_W-1:0];
   assign fetch_addr_o = pc_q[IMPL_W-1:0];

   // R7
   irq_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_i |=> pc_o == PC_W'(VECTOR));
   // R4
   goto_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (goto_i && !irq_i && !call_i) |=> fetch_addr_o[TGT_W-1:0] == $past(target_i));
   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(step_i || pcl_wr_i || goto_i || call_i || ret_i || irq_i) |=> $stable(pc_o));
   // R2
   step_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !(pcl_wr_i || goto_i || call_i || ret_i || irq_i))
      |=> pc_o == PC_W'($past(pc_o) + 1'b1));
   // R10
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hi_wr_i |=> $stable(latch_q));
endmodule

// File: tb/tb_prog_seq.sv
`timescale 1ns/1ps
module tb_prog_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step_i = 0, pcl_wr_i = 0, goto_i = 0, call_i = 0, ret_i = 0, irq_i = 0, hi_wr_i = 0;
   logic [10:0] target_i = '0;
   logic [7:0]  data_i = '0;
   logic [12:0] pc_o;
   logic [7:0]  pcl_o;
   logic [10:0] fetch_addr_o;

   int total = 0;
   int bad = 0;
   bit done = 0;

   logic [12:0] m_pc;
   logic [4:0]  m_latch;
   logic [12:0] m_stk [8];
   logic [2:0]  m_sp;

   always #2.5 clk = ~clk;

   prog_seq dut (
      .clk (clk), .rst_n (rst_n), .step_i (step_i), .pcl_wr_i (pcl_wr_i),
      .goto_i (goto_i), .call_i (call_i), .ret_i (ret_i), .irq_i (irq_i),
      .hi_wr_i (hi_wr_i), .target_i (target_i), .data_i (data_i),
      .pc_o (pc_o), .pcl_o (pcl_o), .fetch_addr_o (fetch_addr_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic string tag_of(bit s, bit p, bit g, bit c, bit r, bit q);
      int n = s + p + g + c + r + q;
      if (n > 1) return "R8";
      if (q) return "R7";
      if (c) return "R5";
      if (g) return "R4";
      if (r) return "R6";
      if (p) return "R3";
      if (s) return "R2";
      return "R8";
   endfunction

   task automatic m_push(input logic [12:0] v);
      m_stk[m_sp] = v;
      m_sp = m_sp + 3'd1;
   endtask

   // one cycle: drive at negedge, update model, check at next negedge
   task automatic cyc(input bit s, input bit p, input bit g, input bit c, input bit r,
                      input bit q, input bit lw, input logic [7:0] d, input logic [10:0] t,
                      input string tag);
      logic [12:0] nxt;
      step_i = s; pcl_wr_i = p; goto_i = g; call_i = c; ret_i = r; irq_i = q;
      hi_wr_i = lw; data_i = d; target_i = t;
      if (q) begin m_push(m_pc); nxt = 13'h0004; end
      else if (c) begin m_push(m_pc + 13'd1); nxt = {m_latch[4:3], t}; end
      else if (g) nxt = {m_latch[4:3], t};
      else if (r) begin m_sp = m_sp - 3'd1; nxt = m_stk[m_sp]; end
      else if (p) nxt = {m_latch, d};
      else if (s) nxt = m_pc + 13'd1;
      else nxt = m_pc;
      if (lw) m_latch = d[4:0];
      m_pc = nxt;
      @(posedge clk);
      @(negedge clk);
      chk(tag, 32'(pc_o), 32'(m_pc));
      chk("R12", 32'(pcl_o), 32'(m_pc[7:0]));
      chk("R11", 32'(fetch_addr_o), 32'(m_pc[10:0]));
   endtask

   initial begin
      #1000000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      m_pc = '0; m_latch = '0; m_sp = '0;
      for (int i = 0; i < 8; i++) m_stk[i] = '0;
      repeat (3) @(negedge clk);
      chk("R1 reset pc", 32'(pc_o), 32'h0);
      chk("R1 reset pcl", 32'(pcl_o), 32'h0);
      rst_n = 1'b1;
      // R1/R6: pop right after reset gives cleared entry
      cyc(0,0,0,0,1,0,0, 8'h00, 11'h000, "R1 pop after reset");
      // R2 plain steps
      cyc(1,0,0,0,0,0,0, 8'h00, 11'h000, "R2");
      cyc(1,0,0,0,0,0,0, 8'h00, 11'h000, "R2");
      // R10: latch write together with byte write uses the old latch (0)
      cyc(0,1,0,0,0,0,1, 8'hFF, 11'h000, "R10 same-cycle byte write");
      chk("R10 old latch", 32'(pc_o), 32'h00FF);
      // latch now 1F; byte write -> 1FFF, then step wraps to 0
      cyc(0,1,0,0,0,0,0, 8'hFF, 11'h000, "R3");
      chk("R11 top of space", 32'(fetch_addr_o), 32'h7FF);
      cyc(1,0,0,0,0,0,0, 8'h00, 11'h000, "R2 wrap");
      chk("R2 wrap to zero", 32'(pc_o), 32'h0);
      // R4 jump with latch bits 4:3 = 11; latch write same cycle to 00
      cyc(0,0,1,0,0,0,1, 8'h00, 11'h123, "R10 same-cycle jump");
      chk("R4 jump upper bits", 32'(pc_o), 32'h1923);
      // R9: nine calls then nine returns
      for (int i = 0; i < 9; i++)
         cyc(0,0,0,1,0,0,0, 8'h00, 11'(16 * (i + 1)), "R9 push");
      for (int i = 0; i < 9; i++)
         cyc(0,0,0,0,1,0,0, 8'h00, 11'h000, "R9 pop");
      chk("R9 ninth pop repeats newest", 32'(pc_o), 32'h0081);
      // R7 with coincident return: interrupt wins, then return comes back
      cyc(0,1,0,0,0,0,1, 8'h05, 11'h000, "R3");
      cyc(0,0,0,0,1,1,0, 8'h00, 11'h000, "R7 irq over ret");
      chk("R7 vector", 32'(pc_o), 32'h0004);
      cyc(0,0,0,0,1,0,0, 8'h00, 11'h000, "R7 return to interrupted word");
      chk("R7 pushed current pc", 32'(pc_o), 32'h0005);
      // R10: pops/pushes leave latch alone, seen through next byte write
      cyc(0,0,0,1,0,0,0, 8'h00, 11'h010, "R5");
      cyc(0,0,0,0,1,0,0, 8'h00, 11'h000, "R6");
      cyc(0,1,0,0,0,0,0, 8'h33, 11'h000, "R10 latch kept");
      chk("R10 latch after stack ops", 32'(pc_o), 32'h0533);
      // random mix
      for (int n = 0; n < 4000; n++) begin
         bit s = ($urandom % 2) == 0;
         bit p = ($urandom % 8) == 0;
         bit g = ($urandom % 8) == 0;
         bit c = ($urandom % 7) == 0;
         bit r = ($urandom % 7) == 0;
         bit q = ($urandom % 12) == 0;
         bit lw = ($urandom % 6) == 0;
         logic [7:0] d = 8'($urandom);
         logic [10:0] t = 11'($urandom);
         cyc(s, p, g, c, r, q, lw, d, t, tag_of(s, p, g, c, r, q));
      end
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule